// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block keeps the stores that are in flight, in the order the program issued them, and answers loads against them. Each store is allocated with a sequence tag. Its translated word address, byte mask and data then arrive separately, each one found by its tag. A commit strobe marks the oldest store that is not yet committed. The head store is written to a plain data-cache write port only after it is committed and both its address and its data are known. Stores therefore reach memory strictly in program order.

A load presents its word address, its byte mask and its sequence tag. In the same cycle the buffer searches every store that the tag shows to be older than the load and returns one of four outcomes:
- **hit**: forwarded data from the youngest older store that matches.
- **miss**: the cache may be read.
- **unknown**: an older store still has no address and nothing matched.
- **stall**: the youngest overlapping store has a different byte mask, or its data has not arrived.

A flush discards every uncommitted store. Committed stores stay in the buffer and drain as usual.

Top module: `store_fwd_buffer`

## Requirements
- R1: `alloc_ready` is 1 exactly when fewer than DEPTH stores are held. A request made while the buffer is full, or in a flush cycle, allocates nothing.
- R2: `wr_valid` is 1 only when the oldest held store is committed and has both its address and its data. Commits take effect one at a time, oldest uncommitted store first.
- R3: Stores leave through the write port in allocation order, carrying their own address, mask and data. A presented write is held unchanged until `wr_ready` accepts it.
- R4: A store counts as older than a load when (load_tag − store_tag) mod 2^TAG_W is nonzero and below 2^(TAG_W−1). A load ignores every store that is not older than it.
- R5: When the youngest older store with a known address that overlaps the load (same word and at least one shared mask bit) has exactly the load's mask and its data, the load gets `ld_hit` with that store's data.
- R6: When no older store overlaps and every older store has a known address, the load gets `ld_miss`.
- R7: When no older store with a known address overlaps but some older store has an unknown address, the load gets `ld_unknown`.
- R8: When the youngest overlapping older store has a mask different from the load's, or has no data yet, the load gets `ld_stall`.
- R9: Stores to the same word whose masks share no bit with the load's mask do not count as overlapping.
- R10: A flush removes all uncommitted stores at the clock edge. A commit in the same cycle is applied first, and committed stores still drain.
- R11: While `ld_valid` is 1, exactly one of `ld_hit`, `ld_miss`, `ld_unknown`, `ld_stall` is 1. While it is 0, all four are 0.
- R12: After reset the buffer is empty: `alloc_ready` is 1 and `wr_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a new store |
| alloc_tag | input | TAG_W | Sequence tag of the new store |
| alloc_ready | output | 1 | Buffer has room |
| addr_valid | input | 1 | Address delivery for a held store |
| addr_tag | input | TAG_W | Tag of the store receiving the address |
| addr_word | input | ADDR_W | Word address |
| addr_mask | input | DATA_W/8 | Byte mask |
| data_valid | input | 1 | Data delivery for a held store |
| data_tag | input | TAG_W | Tag of the store receiving data |
| data_value | input | DATA_W | Store data |
| commit_valid | input | 1 | Commit the oldest uncommitted store |
| flush | input | 1 | Discard uncommitted stores |
| wr_valid | output | 1 | Cache write request |
| wr_addr | output | ADDR_W | Cache write word address |
| wr_mask | output | DATA_W/8 | Cache write byte mask |
| wr_data | output | DATA_W | Cache write data |
| wr_ready | input | 1 | Cache accepts the write |
| ld_valid | input | 1 | Load lookup request |
| ld_tag | input | TAG_W | Load sequence tag |
| ld_addr | input | ADDR_W | Load word address |
| ld_mask | input | DATA_W/8 | Load byte mask |
| ld_hit | output | 1 | Data forwarded |
| ld_data | output | DATA_W | Forwarded data |
| ld_miss | output | 1 | Load may read the cache |
| ld_unknown | output | 1 | Older store address not yet known |
| ld_stall | output | 1 | Partial overlap or missing data |

## Verification
The load outcome and the forwarded data are combinational in the current state, so they are due in the same cycle as the request. The bench drives inputs just after the falling edge and compares the outcome one time step later. Allocation, address, data, commit, flush and drain requests take effect at the next rising edge, so `alloc_ready` and the write port reflect them one cycle later. The bench reference model therefore applies each cycle's stimulus only after the edge, and the next cycle's comparisons run against the updated model. Every cycle compares the write port against the model's head entry, including its hold while `wr_ready` is low.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
   typedef enum logic [1:0] {
      LK_MISS    = 2'd0,
      LK_HIT     = 2'd1,
      LK_UNKNOWN = 2'd2,
      LK_STALL   = 2'd3
   } lookup_e;
endpackage

// File: rtl/sbuf_ptr_ctrl.sv
module sbuf_ptr_ctrl #(
   parameter int DEPTH = 8,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int PTR_W = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_req,
   input  logic             commit_req,
   input  logic             flush,
   input  logic             drain,
   output logic [IDX_W-1:0] head_idx,
   output logic [IDX_W-1:0] tail_idx,
   output logic [DEPTH-1:0] live,
   output logic             full,
   output logic             head_committed,
   output logic             alloc_fire
);
   logic [PTR_W-1:0] head_q, cmt_q, tail_q;
   logic [PTR_W-1:0] count, cmt_n, tail_n;
   logic             commit_fire;

   assign count          = tail_q - head_q;
   assign full           = (count == PTR_W'(DEPTH));
   assign head_committed = (cmt_q != head_q);
   assign commit_fire    = commit_req && (cmt_q != tail_q);
   assign alloc_fire     = alloc_req && !full && !flush;
   assign cmt_n          = cmt_q + PTR_W'(commit_fire);
   assign tail_n         = flush ? cmt_n : tail_q + PTR_W'(alloc_fire);
   assign head_idx       = head_q[IDX_W-1:0];
   assign tail_idx       = tail_q[IDX_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         cmt_q  <= '0;
         tail_q <= '0;
      end else begin
         head_q <= head_q + PTR_W'(drain);
         cmt_q  <= cmt_n;
         tail_q <= tail_n;
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_live
      logic [IDX_W-1:0] pos;
      assign pos     = IDX_W'(i) - head_idx;
      assign live[i] = ({1'b0, pos} < count);
   end

   p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      count <= PTR_W'(DEPTH));
   p_commit_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmt_q - head_q) <= count);
   p_flush_trim_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (tail_q == cmt_q));
endmodule

// File: rtl/sbuf_entries.sv
module sbuf_entries #(
   parameter int DEPTH  = 8,
   parameter int TAG_W  = 8,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int NB    = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_fire,
   input  logic [IDX_W-1:0]  tail_idx,
   input  logic [TAG_W-1:0]  alloc_tag,
   input  logic [DEPTH-1:0]  live,
   input  logic              addr_valid,
   input  logic [TAG_W-1:0]  addr_tag,
   input  logic [ADDR_W-1:0] addr_word,
   input  logic [NB-1:0]     addr_mask,
   input  logic              data_valid,
   input  logic [TAG_W-1:0]  data_tag,
   input  logic [DATA_W-1:0] data_value,
   output logic [TAG_W-1:0]  e_tag  [DEPTH],
   output logic              e_av   [DEPTH],
   output logic [ADDR_W-1:0] e_addr [DEPTH],
   output logic [NB-1:0]     e_mask [DEPTH],
   output logic              e_dv   [DEPTH],
   output logic [DATA_W-1:0] e_data [DEPTH]
);
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic take_new, take_addr, take_data;
      assign take_new  = alloc_fire && (tail_idx == IDX_W'(i));
      assign take_addr = addr_valid && live[i] && (e_tag[i] == addr_tag);
      assign take_data = data_valid && live[i] && (e_tag[i] == data_tag);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            e_tag[i]  <= '0;
            e_av[i]   <= 1'b0;
            e_addr[i] <= '0;
            e_mask[i] <= '0;
            e_dv[i]   <= 1'b0;
            e_data[i] <= '0;
         end else if (take_new) begin
            e_tag[i] <= alloc_tag;
            e_av[i]  <= 1'b0;
            e_dv[i]  <= 1'b0;
         end else begin
            if (take_addr) begin
               e_av[i]   <= 1'b1;
               e_addr[i] <= addr_word;
               e_mask[i] <= addr_mask;
            end
            if (take_data) begin
               e_dv[i]   <= 1'b1;
               e_data[i] <= data_value;
            end
         end
      end
   end
endmodule

// File: rtl/sbuf_fwd_search.sv
module sbuf_fwd_search
   import sbuf_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int TAG_W  = 8,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int NB    = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  head_idx,
   input  logic [DEPTH-1:0]  live,
   input  logic [TAG_W-1:0]  e_tag  [DEPTH],
   input  logic              e_av   [DEPTH],
   input  logic [ADDR_W-1:0] e_addr [DEPTH],
   input  logic [NB-1:0]     e_mask [DEPTH],
   input  logic              e_dv   [DEPTH],
   input  logic [DATA_W-1:0] e_data [DEPTH],
   input  logic [TAG_W-1:0]  ld_tag,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [NB-1:0]     ld_mask,
   output lookup_e           result,
   output logic [DATA_W-1:0] fwd_data
);
   logic [DEPTH-1:0] older, overlap;
   logic [IDX_W-1:0] slot, sel_slot;
   logic             sel_found, any_unknown;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      logic [TAG_W-1:0] gap;
      assign gap        = ld_tag - e_tag[i];
      assign older[i]   = live[i] && (gap != '0) && !gap[TAG_W-1];
      assign overlap[i] = e_av[i] && (e_addr[i] == ld_addr)
                          && ((e_mask[i] & ld_mask) != '0);
   end

   // walk from oldest to youngest so the last overlap seen is the youngest
   always_comb begin
      slot        = '0;
      sel_slot    = '0;
      sel_found   = 1'b0;
      any_unknown = 1'b0;
      for (int k = 0; k < DEPTH; k++) begin
         slot = head_idx + IDX_W'(k);
         if (older[slot]) begin
            if (!e_av[slot]) begin
               any_unknown = 1'b1;
            end else if (overlap[slot]) begin
               sel_found = 1'b1;
               sel_slot  = slot;
            end
         end
      end
   end

   always_comb begin
      fwd_data = e_data[sel_slot];
      if (sel_found) begin
         result = (e_dv[sel_slot] && (e_mask[sel_slot] == ld_mask)) ? LK_HIT : LK_STALL;
      end else begin
         result = any_unknown ? LK_UNKNOWN : LK_MISS;
      end
   end

   p_hit_has_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (result == LK_HIT) |-> (live != '0));
endmodule

// File: rtl/store_fwd_buffer.sv
module store_fwd_buffer
   import sbuf_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int TAG_W  = 8,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int NB    = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_valid,
   input  logic [TAG_W-1:0]  alloc_tag,
   output logic              alloc_ready,
   input  logic              addr_valid,
   input  logic [TAG_W-1:0]  addr_tag,
   input  logic [ADDR_W-1:0] addr_word,
   input  logic [NB-1:0]     addr_mask,
   input  logic              data_valid,
   input  logic [TAG_W-1:0]  data_tag,
   input  logic [DATA_W-1:0] data_value,
   input  logic              commit_valid,
   input  logic              flush,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [NB-1:0]     wr_mask,
   output logic [DATA_W-1:0] wr_data,
   input  logic              wr_ready,
   input  logic              ld_valid,
   input  logic [TAG_W-1:0]  ld_tag,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [NB-1:0]     ld_mask,
   output logic              ld_hit,
   output logic [DATA_W-1:0] ld_data,
   output logic              ld_miss,
   output logic              ld_unknown,
   output logic              ld_stall
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("store_fwd_buffer: DEPTH must be a power of two of at least 2");
   end
   if (DATA_W < 8 || DATA_W % 8 != 0) begin : g_bad_width
      $error("store_fwd_buffer: DATA_W must be a whole number of bytes");
   end
   if (TAG_W < IDX_W + 2) begin : g_bad_tag
      $error("store_fwd_buffer: TAG_W too narrow for the age window");
   end

   logic [IDX_W-1:0]  head_idx, tail_idx;
   logic [DEPTH-1:0]  live;
   logic              full, head_committed, alloc_fire, drain;
   logic [TAG_W-1:0]  e_tag  [DEPTH];
   logic              e_av   [DEPTH];
   logic [ADDR_W-1:0] e_addr [DEPTH];
   logic [NB-1:0]     e_mask [DEPTH];
   logic              e_dv   [DEPTH];
   logic [DATA_W-1:0] e_data [DEPTH];
   lookup_e           result;
   logic [DATA_W-1:0] fwd_data;

   assign alloc_ready = !full;
   assign wr_valid    = head_committed && e_av[head_idx] && e_dv[head_idx];
   assign wr_addr     = e_addr[head_idx];
   assign wr_mask     = e_mask[head_idx];
   assign wr_data     = e_data[head_idx];
   assign drain       = wr_valid && wr_ready;

   sbuf_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .alloc_req(alloc_valid), .commit_req(commit_valid),
      .flush(flush), .drain(drain), .head_idx(head_idx), .tail_idx(tail_idx),
      .live(live), .full(full), .head_committed(head_committed), .alloc_fire(alloc_fire)
   );

   sbuf_entries #(.DEPTH(DEPTH), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ent (
      .clk(clk), .rst_n(rst_n), .alloc_fire(alloc_fire), .tail_idx(tail_idx),
      .alloc_tag(alloc_tag), .live(live),
      .addr_valid(addr_valid), .addr_tag(addr_tag), .addr_word(addr_word), .addr_mask(addr_mask),
      .data_valid(data_valid), .data_tag(data_tag), .data_value(data_value),
      .e_tag(e_tag), .e_av(e_av), .e_addr(e_addr), .e_mask(e_mask), .e_dv(e_dv), .e_data(e_data)
   );

   sbuf_fwd_search #(.DEPTH(DEPTH), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_srch (
      .clk(clk), .rst_n(rst_n), .head_idx(head_idx), .live(live),
      .e_tag(e_tag), .e_av(e_av), .e_addr(e_addr), .e_mask(e_mask), .e_dv(e_dv), .e_data(e_data),
      .ld_tag(ld_tag), .ld_addr(ld_addr), .ld_mask(ld_mask),
      .result(result), .fwd_data(fwd_data)
   );

   assign ld_hit     = ld_valid && (result == LK_HIT);
   assign ld_miss    = ld_valid && (result == LK_MISS);
   assign ld_unknown = ld_valid && (result == LK_UNKNOWN);
   assign ld_stall   = ld_valid && (result == LK_STALL);
   assign ld_data    = fwd_data;

   p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({ld_hit, ld_miss, ld_unknown, ld_stall}) == (ld_valid ? 1 : 0));
   p_write_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready && !addr_valid && !data_valid)
         |=> (wr_valid && $stable(wr_addr) && $stable(wr_mask) && $stable(wr_data)));
   p_reset_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (alloc_ready && !wr_valid));
endmodule

// File: tb/store_fwd_buffer_test.sv
module store_fwd_buffer_test;
   localparam int DEPTH = 8, TAG_W = 8, ADDR_W = 16, DATA_W = 32, NB = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic alloc_valid = 0, addr_valid = 0, data_valid = 0, commit_valid = 0, flush = 0;
   logic wr_ready = 0, ld_valid = 0;
   logic [TAG_W-1:0]  alloc_tag = 0, addr_tag = 0, data_tag = 0, ld_tag = 0;
   logic [ADDR_W-1:0] addr_word = 0, ld_addr = 0;
   logic [NB-1:0]     addr_mask = 0, ld_mask = 0;
   logic [DATA_W-1:0] data_value = 0;
   logic alloc_ready, wr_valid, ld_hit, ld_miss, ld_unknown, ld_stall;
   logic [ADDR_W-1:0] wr_addr;
   logic [NB-1:0]     wr_mask;
   logic [DATA_W-1:0] wr_data, ld_data;

   store_fwd_buffer #(.DEPTH(DEPTH), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
      .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_tag(alloc_tag),
      .alloc_ready(alloc_ready), .addr_valid(addr_valid), .addr_tag(addr_tag),
      .addr_word(addr_word), .addr_mask(addr_mask), .data_valid(data_valid),
      .data_tag(data_tag), .data_value(data_value), .commit_valid(commit_valid),
      .flush(flush), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_mask(wr_mask),
      .wr_data(wr_data), .wr_ready(wr_ready), .ld_valid(ld_valid), .ld_tag(ld_tag),
      .ld_addr(ld_addr), .ld_mask(ld_mask), .ld_hit(ld_hit), .ld_data(ld_data),
      .ld_miss(ld_miss), .ld_unknown(ld_unknown), .ld_stall(ld_stall)
   );

   int checks = 0, fails = 0;
   bit done = 0;

   // reference model: position 0 is the oldest held store
   logic [TAG_W-1:0]  m_tag  [DEPTH];
   logic              m_ak   [DEPTH];
   logic [ADDR_W-1:0] m_addr [DEPTH];
   logic [NB-1:0]     m_mask [DEPTH];
   logic              m_dk   [DEPTH];
   logic [DATA_W-1:0] m_data [DEPTH];
   int m_cnt = 0, m_cmt = 0;
   logic [TAG_W-1:0] next_tag = 0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit is_older(input logic [TAG_W-1:0] st, input logic [TAG_W-1:0] ld);
      logic [TAG_W-1:0] gap;
      gap = ld - st;
      return (gap != 0) && !gap[TAG_W-1];
   endfunction

   // expected outcome: 0 miss, 1 hit, 2 unknown, 3 stall
   function automatic int exp_outcome(output logic [DATA_W-1:0] d);
      int sel = -1;
      bit unk = 0;
      d = 0;
      for (int k = 0; k < m_cnt; k++) begin
         if (is_older(m_tag[k], ld_tag)) begin
            if (!m_ak[k]) unk = 1;
            else if (m_addr[k] == ld_addr && (m_mask[k] & ld_mask) != 0) sel = k;
         end
      end
      if (sel >= 0) begin
         d = m_data[sel];
         return (m_dk[sel] && m_mask[sel] == ld_mask) ? 1 : 3;
      end
      return unk ? 2 : 0;
   endfunction

   task automatic cycle();
      logic [DATA_W-1:0] ed;
      int eo, pre_cnt, pre_cmt;
      bit ewv, drain;
      #1;
      chk(alloc_ready == (m_cnt < DEPTH), "R1 alloc_ready", alloc_ready, m_cnt < DEPTH);
      ewv = (m_cmt > 0) && m_ak[0] && m_dk[0];
      chk(wr_valid == ewv, "R2 wr_valid", wr_valid, ewv);
      if (ewv) chk({wr_addr, wr_mask, wr_data} == {m_addr[0], m_mask[0], m_data[0]},
                   "R3 write order/content", {wr_addr, wr_mask, wr_data[31:0]},
                   {m_addr[0], m_mask[0], m_data[0]});
      if (ld_valid) begin
         eo = exp_outcome(ed);
         chk($countones({ld_hit, ld_miss, ld_unknown, ld_stall}) == 1, "R11 one outcome",
             {ld_hit, ld_miss, ld_unknown, ld_stall}, 1);
         case (eo)
            0: chk(ld_miss, "R6 R4 miss", {ld_hit, ld_miss, ld_unknown, ld_stall}, 4'b0100);
            1: begin
               chk(ld_hit, "R5 hit", {ld_hit, ld_miss, ld_unknown, ld_stall}, 4'b1000);
               chk(ld_data == ed, "R5 forwarded data", ld_data, ed);
            end
            2: chk(ld_unknown, "R7 unknown", {ld_hit, ld_miss, ld_unknown, ld_stall}, 4'b0010);
            default: chk(ld_stall, "R8 stall", {ld_hit, ld_miss, ld_unknown, ld_stall}, 4'b0001);
         endcase
      end else begin
         chk({ld_hit, ld_miss, ld_unknown, ld_stall} == 0, "R11 idle", {ld_hit, ld_miss, ld_unknown, ld_stall}, 0);
      end
      @(posedge clk);
      pre_cnt = m_cnt;
      pre_cmt = m_cmt;
      drain = ewv && wr_ready;
      for (int k = 0; k < pre_cnt; k++) begin
         if (addr_valid && m_tag[k] == addr_tag) begin
            m_ak[k] = 1; m_addr[k] = addr_word; m_mask[k] = addr_mask;
         end
         if (data_valid && m_tag[k] == data_tag) begin
            m_dk[k] = 1; m_data[k] = data_value;
         end
      end
      if (drain) begin
         for (int k = 0; k < DEPTH - 1; k++) begin
            m_tag[k] = m_tag[k+1]; m_ak[k] = m_ak[k+1]; m_addr[k] = m_addr[k+1];
            m_mask[k] = m_mask[k+1]; m_dk[k] = m_dk[k+1]; m_data[k] = m_data[k+1];
         end
         m_cnt--; m_cmt--;
      end
      if (commit_valid && pre_cmt < pre_cnt) m_cmt++;
      if (flush) m_cnt = m_cmt;
      else if (alloc_valid && pre_cnt < DEPTH) begin
         m_tag[m_cnt] = alloc_tag; m_ak[m_cnt] = 0; m_dk[m_cnt] = 0;
         m_cnt++;
      end
      @(negedge clk);
   endtask

   task automatic idle();
      alloc_valid = 0; addr_valid = 0; data_valid = 0; commit_valid = 0;
      flush = 0; wr_ready = 0; ld_valid = 0;
   endtask

   task automatic alloc_one();
      idle(); alloc_valid = 1; alloc_tag = next_tag; next_tag += 2; cycle();
   endtask

   task automatic give(input logic [TAG_W-1:0] t, input logic [ADDR_W-1:0] a,
                       input logic [NB-1:0] m, input logic [DATA_W-1:0] d, input bit with_data);
      idle(); addr_valid = 1; addr_tag = t; addr_word = a; addr_mask = m;
      data_valid = with_data; data_tag = t; data_value = d; cycle();
   endtask

   task automatic load(input logic [TAG_W-1:0] t, input logic [ADDR_W-1:0] a, input logic [NB-1:0] m);
      idle(); ld_valid = 1; ld_tag = t; ld_addr = a; ld_mask = m; cycle();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      #1;
      chk(alloc_ready == 1 && wr_valid == 0, "R12 reset state", {alloc_ready, wr_valid}, 2'b10);
      @(negedge clk);

      // R4 R5: youngest older match wins, younger match ignored
      alloc_one(); alloc_one(); alloc_one();               // tags 0,2,4
      give(8'd0, 16'd5, 4'hF, 32'h11, 1);
      give(8'd2, 16'd5, 4'hF, 32'h22, 1);
      give(8'd4, 16'd5, 4'hF, 32'h33, 1);
      load(8'd3, 16'd5, 4'hF);
      chk(ld_data == 32'h22, "R5 youngest older wins", ld_data, 32'h22);
      load(8'd3, 16'd5, 4'h3);                             // R8 partial overlap
      load(8'd3, 16'd7, 4'hF);                             // R6 miss
      alloc_one();                                         // tag 6, no address
      load(8'd7, 16'd7, 4'hF);                             // R7 unknown
      load(8'd7, 16'd5, 4'hF);                             // match beats unknown
      give(8'd6, 16'd2, 4'hF, 32'h44, 0);                  // address only
      load(8'd7, 16'd2, 4'hF);                             // R8 data missing
      alloc_one();                                         // tag 8
      give(8'd8, 16'd9, 4'h3, 32'h55, 1);
      load(8'd9, 16'd9, 4'hC);                             // R9 disjoint masks
      chk(ld_miss == 1, "R9 disjoint masks miss", ld_miss, 1);

      // R10: commit two, flush the rest, committed ones drain
      idle(); commit_valid = 1; cycle();
      idle(); commit_valid = 1; flush = 1; cycle();
      idle(); wr_ready = 1; cycle(); cycle(); cycle();
      #1;
      chk(wr_valid == 0 && alloc_ready == 1, "R10 only committed drained", {wr_valid, alloc_ready}, 2'b01);
      @(negedge clk);

      // R1: fill to full and try one more
      for (int i = 0; i < DEPTH + 1; i++) alloc_one();
      #1;
      chk(alloc_ready == 0, "R1 full stalls allocation", alloc_ready, 0);
      @(negedge clk);
      idle(); flush = 1; cycle();

      // random phase
      for (int n = 0; n < 4000; n++) begin
         idle();
         alloc_valid = ($urandom % 100) < 45;
         alloc_tag = next_tag;
         if (alloc_valid && m_cnt < DEPTH && !flush) ; // tag consumed below
         commit_valid = ($urandom % 100) < 35;
         flush = ($urandom % 100) < 3;
         wr_ready = ($urandom % 100) < 70;
         if (m_cnt > 0) begin
            int k = $urandom % m_cnt;
            if (!m_ak[k] && ($urandom % 2)) begin
               addr_valid = 1; addr_tag = m_tag[k]; addr_word = 16'($urandom % 4);
               case ($urandom % 4) 0: addr_mask = 4'hF; 1: addr_mask = 4'h3; 2: addr_mask = 4'hC; default: addr_mask = 4'h1; endcase
            end
            k = $urandom % m_cnt;
            if (!m_dk[k] && ($urandom % 2)) begin
               data_valid = 1; data_tag = m_tag[k]; data_value = $urandom;
            end
         end
         ld_valid = ($urandom % 100) < 60;
         begin
            int k = int'($urandom % (m_cnt + 2)) - 1;
            if (k < 0) ld_tag = (m_cnt > 0) ? m_tag[0] - 8'd1 : next_tag - 8'd1;
            else if (k < m_cnt) ld_tag = m_tag[k] + 8'd1;
            else ld_tag = next_tag - 8'd1;
         end
         ld_addr = 16'($urandom % 4);
         case ($urandom % 4) 0: ld_mask = 4'hF; 1: ld_mask = 4'h3; 2: ld_mask = 4'hC; default: ld_mask = 4'h1; endcase
         if (alloc_valid && m_cnt < DEPTH && !flush) next_tag += 2;
         cycle();
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule